// File: doc/BRIEF.md
# Nibble-Mode DRAM Slot Sequencer

This block runs from a 16 MHz master clock. It splits time into memory slots of eight phases each, so one slot lasts 500 ns. Each slot becomes one byte access to a dynamic RAM that is four bits wide. A single row strobe opens the row. Two column strobes then move the byte as two 4-bit halves, and both halves share one multiplexed 8-bit address bus.

The block also decides who owns each slot, the display fetch or the processor. On an active scanline, a wide display mode gives every slot to the display. A narrow display mode alternates display and processor slots. Outside the active scanline, the processor gets every slot. The processor advances on a one-phase clock-enable. That enable gives 2 MHz, 1 MHz or stopped operation, depending on how the slots are shared.

The owner, address, write flag and write data for a slot are sampled at the clock edge that ends phase 6 of the slot before it. Read data is returned as one byte with a one-phase valid pulse in phase 7. A flag marks whether the returned byte belongs to the display.

Top module: `dram_nibble_seq`

## Requirements
- R1: `ras_n` is low in phases 0 to 5 of every slot and high in phases 6 and 7. It is high throughout reset.
- R2: `cas_n` is low only in phases 2 and 4, so it falls twice while `ras_n` is low. It is high in every other phase.
- R3: For a 15-bit byte address A, `ram_a` is driven as follows:
  - A[14:7] in phase 7 of the previous slot and in phase 0;
  - {A[6:0],0} in phases 1 and 2;
  - {A[6:0],1} in phases 3 to 6.
- R4: For a read, the half sampled at the end of phase 2 becomes `rd_data[3:0]` and the half sampled at the end of phase 4 becomes `rd_data[7:4]`. `rd_valid` is high only in phase 7 of that slot. `rd_video` shows whether the slot was a display slot.
- R5: For a processor write, `we_n` is low and `ram_dq_oe` is high in phases 0 to 5. `ram_dq_o` carries `cpu_wdata[3:0]` in phases 0 to 3 and `cpu_wdata[7:4]` in phases 4 and 5. For reads and display slots, `we_n` stays high and `ram_dq_oe` stays low.
- R6: With `line_active`=1 and `wide_mode`=0, ownership alternates from slot to slot between display and processor.
- R7: With `line_active`=1 and `wide_mode`=1, every slot is a display slot and `cpu_ce` never pulses.
- R8: With `line_active`=0, every slot is a processor slot, whatever the mode.
- R9: `cpu_ce` is a single-phase pulse in phase 7 of each processor slot and is low at all other times. Owner, address, `cpu_we` and `cpu_wdata` are sampled at the edge that ends phase 6 of the preceding slot.
- R10: During reset, `ras_n`, `cas_n` and `we_n` are high, and `ram_dq_oe`, `cpu_ce` and `rd_valid` are low. The first slot's phase 0 follows two clock edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1 selects the 80-byte-per-line display mode |
| line_active | input | 1 | High during the pixel part of a scanline |
| vid_addr | input | 15 | Display fetch byte address |
| cpu_addr | input | 15 | Processor byte address |
| cpu_we | input | 1 | Processor write request |
| cpu_wdata | input | 8 | Processor write byte |
| ram_dq_i | input | 4 | RAM data bus, read direction |
| ram_dq_o | output | 4 | RAM data bus, write direction |
| ram_dq_oe | output | 1 | Drive enable for `ram_dq_o` |
| ram_a | output | 8 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| rd_data | output | 8 | Assembled read byte |
| rd_valid | output | 1 | Read byte valid, phase 7 |
| rd_video | output | 1 | Returned byte came from a display slot |
| cpu_ce | output | 1 | Processor clock-enable pulse |

## Verification
A phase counter that is off by one shows up at once as a strobe in the wrong phase. The next row address would also appear a phase early or late. A bad owner or alternation bit is visible within one slot, through a missing or extra `cpu_ce` or a wrong `rd_video`. A swapped or mis-timed nibble capture corrupts `rd_data` in the phase 7 of that same slot. The bench sweeps all four mode and scanline combinations over many slots. It checks every phase of every slot against an arithmetic model of addresses and RAM contents.

// File: rtl/dram_nibble_seq.sv
module dram_nibble_seq #(
  parameter int RA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wide_mode,
  input  logic                line_active,
  input  logic [2*RA_W-2:0]   vid_addr,
  input  logic [2*RA_W-2:0]   cpu_addr,
  input  logic                cpu_we,
  input  logic [7:0]          cpu_wdata,
  input  logic [3:0]          ram_dq_i,
  output logic [3:0]          ram_dq_o,
  output logic                ram_dq_oe,
  output logic [RA_W-1:0]     ram_a,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic [7:0]          rd_data,
  output logic                rd_valid,
  output logic                rd_video,
  output logic                cpu_ce
);
  localparam int AW = 2*RA_W-1;
  localparam int CW = RA_W-1;

  logic [2:0]    ph;
  logic          alt, live, vid_q, we_q;
  logic [AW-1:0] a_q;
  logic [7:0]    wd_q;
  logic [3:0]    lo_q, hi_q;

  wire grant_vid = line_active && (wide_mode || !alt);
  wire in_row    = live && (ph < 3'd6);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= 3'd6;
      alt      <= 1'b0;
      live     <= 1'b0;
      vid_q    <= 1'b0;
      we_q     <= 1'b0;
      a_q      <= '0;
      wd_q     <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      rd_valid <= 1'b0;
      rd_video <= 1'b0;
      cpu_ce   <= 1'b0;
    end else begin
      ph       <= ph + 3'd1;
      rd_valid <= 1'b0;
      cpu_ce   <= 1'b0;
      if (ph == 3'd2) lo_q <= ram_dq_i;
      if (ph == 3'd4) hi_q <= ram_dq_i;
      if (ph == 3'd6) begin
        rd_valid <= live && !we_q;
        rd_video <= vid_q;
        cpu_ce   <= live && !vid_q;
        live     <= 1'b1;
        alt      <= ~alt;
        vid_q    <= grant_vid;
        we_q     <= !grant_vid && cpu_we;
        a_q      <= grant_vid ? vid_addr : cpu_addr;
        wd_q     <= cpu_wdata;
      end
    end
  end

  always_comb begin
    case (ph)
      3'd7, 3'd0: ram_a = a_q[AW-1:CW];
      3'd1, 3'd2: ram_a = {a_q[CW-1:0], 1'b0};
      default:    ram_a = {a_q[CW-1:0], 1'b1};
    endcase
  end

  assign ras_n     = !in_row;
  assign cas_n     = !(live && (ph == 3'd2 || ph == 3'd4));
  assign we_n      = !(in_row && we_q);
  assign ram_dq_oe = in_row && we_q;
  assign ram_dq_o  = (ph < 3'd4) ? wd_q[3:0] : wd_q[7:4];
  assign rd_data   = {hi_q, lo_q};

  p_cas_in_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  p_row_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $stable(ram_a));
  p_col_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $stable(ram_a));
  p_we_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $stable(we_n));
  p_ce_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ce |=> !cpu_ce);
  p_rdv_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (ras_n && cas_n));
  p_ras_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> ras_n);
endmodule

// File: tb/dram_nibble_seq_bench.sv
module dram_nibble_seq_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, wide_mode, line_active, cpu_we;
  logic [14:0] vid_addr, cpu_addr;
  logic [7:0]  cpu_wdata;
  logic [3:0]  ram_dq_i, ram_dq_o;
  logic        ram_dq_oe, ras_n, cas_n, we_n, rd_valid, rd_video, cpu_ce;
  logic [7:0]  ram_a, rd_data;

  dram_nibble_seq u_dram_nibble_seq (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .line_active(line_active),
    .vid_addr(vid_addr), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .ram_dq_i(ram_dq_i), .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe), .ram_a(ram_a),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_video(rd_video), .cpu_ce(cpu_ce));

  int checks = 0;
  int errors = 0;
  bit balt = 0, pv_valid = 0, pv_vid = 0, pv_ce = 0;
  logic [7:0] pv_data = '0;

  task automatic ck(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] nib(input logic [7:0] row, input logic [7:0] col);
    logic [7:0] t;
    t = row * 8'd7 + col * 8'd13 + 8'd3;
    return t[3:0];
  endfunction

  task automatic run_slot(input bit wide, input bit act, input int k);
    logic [14:0] va, ca, a;
    logic [7:0] wd, row, c0, c1;
    logic [3:0] n0, n1;
    bit vid, we, cw;
    string otag;
    va = 15'((k * 32'h2b3d + 32'h11));
    ca = 15'((k * 32'h1f07) ^ 32'h5a5a);
    if (k == 0) begin va = 15'h0000; ca = 15'h7fff; end
    cw = k[0] ^ k[1];
    wd = 8'(k * 37 + 5);
    wide_mode = wide; line_active = act;
    vid_addr = va; cpu_addr = ca; cpu_we = cw; cpu_wdata = wd;
    vid = act && (wide || !balt);
    balt = ~balt;
    a = vid ? va : ca;
    we = !vid && cw;
    row = a[14:7]; c0 = {a[6:0], 1'b0}; c1 = {a[6:0], 1'b1};
    n0 = nib(row, c0); n1 = nib(row, c1);
    otag = act ? (wide ? "R7" : "R6") : "R8";
    @(posedge clk); @(negedge clk);
    ck("R3", "row addr ph7", ram_a, row);
    ck("R1", "ras ph7", ras_n, 1);
    ck("R2", "cas ph7", cas_n, 1);
    ck("R4", "rd_valid ph7", rd_valid, pv_valid);
    if (pv_valid) begin
      ck("R4", "rd_data", rd_data, pv_data);
      ck(otag, "rd_video", rd_video, pv_vid);
    end
    ck(otag, "cpu_ce ph7", cpu_ce, pv_ce);
    for (int p = 0; p < 7; p++) begin
      @(posedge clk); @(negedge clk);
      ck("R1", "ras", ras_n, (p < 6) ? 0 : 1);
      ck("R2", "cas", cas_n, (p == 2 || p == 4) ? 0 : 1);
      ck("R3", "addr", ram_a, (p == 0) ? row : (p < 3) ? c0 : c1);
      ck("R5", "we_n", we_n, (we && p < 6) ? 0 : 1);
      ck("R5", "oe", ram_dq_oe, (we && p < 6) ? 1 : 0);
      if (we && p < 6) ck("R5", "wdata", ram_dq_o, (p < 4) ? wd[3:0] : wd[7:4]);
      ck("R9", "cpu_ce off", cpu_ce, 0);
      ck("R4", "rd_valid off", rd_valid, 0);
      if (p == 2) ram_dq_i = n0;
      if (p == 4) ram_dq_i = n1;
    end
    pv_valid = !we; pv_data = {n1, n0}; pv_vid = vid; pv_ce = !vid;
  endtask

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; wide_mode = 0; line_active = 0; cpu_we = 0;
    vid_addr = '0; cpu_addr = '0; cpu_wdata = '0; ram_dq_i = '0;
    repeat (3) @(negedge clk);
    ck("R10", "ras reset", ras_n, 1);
    ck("R10", "cas reset", cas_n, 1);
    ck("R10", "we reset", we_n, 1);
    ck("R10", "oe reset", ram_dq_oe, 0);
    ck("R10", "ce reset", cpu_ce, 0);
    ck("R10", "rdv reset", rd_valid, 0);
    rst_n = 1;
    for (int cfg = 0; cfg < 4; cfg++)
      for (int s = 0; s < 10; s++)
        run_slot(cfg[1], cfg[0], s + cfg * 10);
    run_slot(0, 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule